// File: doc/BRIEF.md
# Floating-Point Status Flag Register

This block is the status and control word of a floating-point accelerator. Each cycle the execute stage can send it update strobes, one per instruction class, together with result qualifiers. Arithmetic results feed two sticky exception flags, overflow and underflow. Moves, compares, min/max, absolute value, negate and integer results feed the negative and zero flags. A dedicated condition-test instruction feeds the test flag. The same word also holds a rounding-mode bit, a bit that lets the accelerator write protected peripheral registers, and a return program counter field that a call loads.

Software saves the whole word through the store port and restores it with a single-cycle load. This lets nested calls keep their return addresses on a software stack. The two sticky exception flags are also driven out as interrupt lines to the host. A parameter selects whether each line is a level that follows its flag or a one-cycle pulse when the flag goes from clear to set.

Top module: `fpu_status_reg`

## Requirements
- R1: `ovf_flag` (word bit 0) and `unf_flag` (word bit 1) are set by `upd_arith` when the matching qualifier is 1. A strobe whose qualifier is 0 never clears them. Only a load of 0 into the bit clears them.
- R2: With `IRQ_PULSE`=1, an interrupt line is high for exactly one cycle, in the cycle in which its flag first reads 1 after being 0. With `IRQ_PULSE`=0, the line equals the flag.
- R3: `neg_flag` (bit 2) and `zero_flag` (bit 3) take `neg_in` and `zero_in` only in the cycle after `upd_nz`. Otherwise they keep their values unless a load writes them.
- R4: `test_flag` (bit 4) takes `test_in` only on `upd_test`.
- R5: A strobe changes only the flags of its own class. All other bits of the word keep their values.
- R6: `call_en` loads `call_pc` into the return field at word bits [RPC_LSB +: RPC_W]. When a load arrives in the same cycle, the call wins for that field.
- R7: `ld_en` writes every defined bit of the word from `ld_data` in one cycle. `stat_word` presents the same layout, with undefined bits reading 0, so a stored word restores the register exactly.
- R8: When a sticky set and a load that clears the same flag arrive in the same cycle, the flag ends up set.
- R9: `rnd_nearest` (bit 5) selects round to nearest even when 1 and round toward zero when 0. `prot_wr_en` (bit 6) enables protected writes when 1. Both change only by load.
- R10: After reset the whole word, the return field and both interrupt lines are 0.
- R11: When a flag strobe and a load arrive in the same cycle, the strobe wins for the flags of its class. The load sets the rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_arith | input | 1 | Float arithmetic result strobe |
| ovf_in | input | 1 | Overflow qualifier of the arithmetic result |
| unf_in | input | 1 | Underflow qualifier of the arithmetic result |
| upd_nz | input | 1 | Move/compare/integer result strobe |
| neg_in | input | 1 | Negative qualifier |
| zero_in | input | 1 | Zero qualifier |
| upd_test | input | 1 | Condition-test instruction strobe |
| test_in | input | 1 | Evaluated test condition |
| call_en | input | 1 | Call: capture return address |
| call_pc | input | RPC_W | Return address to capture |
| ld_en | input | 1 | Load whole word (restore) |
| ld_data | input | DATA_W | Word to load |
| stat_word | output | DATA_W | Whole word for store (save) |
| ovf_flag | output | 1 | Latched overflow |
| unf_flag | output | 1 | Latched underflow |
| neg_flag | output | 1 | Negative flag |
| zero_flag | output | 1 | Zero flag |
| test_flag | output | 1 | Test flag |
| rnd_nearest | output | 1 | Rounding mode, 1 = nearest even |
| prot_wr_en | output | 1 | Protected write enable |
| ret_pc | output | RPC_W | Return program counter field |
| ovf_irq | output | 1 | Overflow interrupt line to host |
| unf_irq | output | 1 | Underflow interrupt line to host |

## Verification
The bench drives two instances from the same stimulus. The first uses pulse interrupts and a 16-bit return field at bit 16. The second uses level interrupts and an 8-bit return field at bit 20. With both running, each interrupt variant is compared against the other in the same cycles. The narrow field shows that the return field is truncated and placed at its offset, and that a word saved from one layout reloads into the other through the offset alone. Same-cycle collisions (set against clear, strobe against load, call against load) are driven on purpose.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int unsigned BIT_OVF   = 0;
   localparam int unsigned BIT_UNF   = 1;
   localparam int unsigned BIT_NEG   = 2;
   localparam int unsigned BIT_ZRO   = 3;
   localparam int unsigned BIT_TST   = 4;
   localparam int unsigned BIT_RND   = 5;
   localparam int unsigned BIT_PRT   = 6;
   localparam int unsigned CTL_BITS  = 7;
   localparam int unsigned N_STICKY  = 2;

   typedef struct packed {
      logic neg;
      logic zero;
      logic test;
   } cond_t;
endpackage

// File: rtl/fsr_sticky_bit.sv
module fsr_sticky_bit #(
   parameter bit IRQ_PULSE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ld_en,
   input  logic ld_val,
   output logic flag_o,
   output logic irq_o
);
   logic flag_q;
   logic flag_d;

   // a set beats any load in the same cycle
   always_comb flag_d = set_i | (ld_en ? ld_val : flag_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag_o = flag_q;

   generate
      if (IRQ_PULSE) begin : g_pulse
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= flag_d & ~flag_q;
         end
         assign irq_o = irq_q;

         p_irq_with_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> flag_o);
         p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |=> !irq_o);
      end else begin : g_level
         assign irq_o = flag_q;
      end
   endgenerate

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   p_sticky_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !ld_en) |=> flag_o);
endmodule

// File: rtl/fsr_cond_flags.sv
module fsr_cond_flags
   import fsr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  upd_nz,
   input  logic  upd_test,
   input  cond_t res_in,
   input  logic  ld_en,
   input  cond_t ld_val,
   output cond_t cond_o
);
   cond_t cond_q;
   cond_t cond_d;

   always_comb begin
      cond_d = ld_en ? ld_val : cond_q;
      if (upd_nz) begin
         cond_d.neg  = res_in.neg;
         cond_d.zero = res_in.zero;
      end
      if (upd_test) cond_d.test = res_in.test;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= '0;
      else        cond_q <= cond_d;
   end

   assign cond_o = cond_q;

   p_nz_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_nz && !ld_en) |=> ($stable(cond_o.neg) && $stable(cond_o.zero)));
   p_test_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_test && !ld_en) |=> $stable(cond_o.test));
   p_nz_beats_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      upd_nz |=> (cond_o.neg == $past(res_in.neg) && cond_o.zero == $past(res_in.zero)));
endmodule

// File: rtl/fsr_ctrl_field.sv
module fsr_ctrl_field #(
   parameter int unsigned RPC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic             ld_rnd,
   input  logic             ld_prt,
   input  logic [RPC_W-1:0] ld_rpc,
   input  logic             call_en,
   input  logic [RPC_W-1:0] call_pc,
   output logic             rnd_o,
   output logic             prt_o,
   output logic [RPC_W-1:0] rpc_o
);
   logic             rnd_q, prt_q;
   logic [RPC_W-1:0] rpc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rnd_q <= 1'b0;
         prt_q <= 1'b0;
         rpc_q <= '0;
      end else begin
         if (ld_en) begin
            rnd_q <= ld_rnd;
            prt_q <= ld_prt;
         end
         if (call_en)    rpc_q <= call_pc;
         else if (ld_en) rpc_q <= ld_rpc;
      end
   end

   assign rnd_o = rnd_q;
   assign prt_o = prt_q;
   assign rpc_o = rpc_q;

   p_call_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      call_en |=> (rpc_o == $past(call_pc)));
   p_rpc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!call_en && !ld_en) |=> $stable(rpc_o));
   p_ctl_load_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> ($stable(rnd_o) && $stable(prt_o)));
endmodule

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
   import fsr_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned RPC_W     = 16,
   parameter int unsigned RPC_LSB   = 16,
   parameter bit          IRQ_PULSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_arith,
   input  logic              ovf_in,
   input  logic              unf_in,
   input  logic              upd_nz,
   input  logic              neg_in,
   input  logic              zero_in,
   input  logic              upd_test,
   input  logic              test_in,
   input  logic              call_en,
   input  logic [RPC_W-1:0]  call_pc,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] ld_data,
   output logic [DATA_W-1:0] stat_word,
   output logic              ovf_flag,
   output logic              unf_flag,
   output logic              neg_flag,
   output logic              zero_flag,
   output logic              test_flag,
   output logic              rnd_nearest,
   output logic              prot_wr_en,
   output logic [RPC_W-1:0]  ret_pc,
   output logic              ovf_irq,
   output logic              unf_irq
);
   localparam int unsigned RPC_MSB = RPC_LSB + RPC_W - 1;

   generate
      if (RPC_W < 1 || RPC_MSB >= DATA_W) begin : g_bad_rpc
         $error("return field does not fit in the word");
      end
      if (RPC_LSB < CTL_BITS) begin : g_bad_lsb
         $error("return field overlaps flag bits");
      end
   endgenerate

   logic [N_STICKY-1:0] st_set, st_ld, st_flag, st_irq;
   cond_t cond_res, cond_ld, cond_q;

   assign st_set[BIT_OVF] = upd_arith & ovf_in;
   assign st_set[BIT_UNF] = upd_arith & unf_in;
   assign st_ld           = ld_data[N_STICKY-1:0];

   generate
      for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
         fsr_sticky_bit #(.IRQ_PULSE(IRQ_PULSE)) u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (st_set[i]),
            .ld_en  (ld_en),
            .ld_val (st_ld[i]),
            .flag_o (st_flag[i]),
            .irq_o  (st_irq[i])
         );
      end
   endgenerate

   assign cond_res = '{neg: neg_in, zero: zero_in, test: test_in};
   assign cond_ld  = '{neg: ld_data[BIT_NEG], zero: ld_data[BIT_ZRO], test: ld_data[BIT_TST]};

   fsr_cond_flags u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_nz   (upd_nz),
      .upd_test (upd_test),
      .res_in   (cond_res),
      .ld_en    (ld_en),
      .ld_val   (cond_ld),
      .cond_o   (cond_q)
   );

   fsr_ctrl_field #(.RPC_W(RPC_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_rnd  (ld_data[BIT_RND]),
      .ld_prt  (ld_data[BIT_PRT]),
      .ld_rpc  (ld_data[RPC_MSB:RPC_LSB]),
      .call_en (call_en),
      .call_pc (call_pc),
      .rnd_o   (rnd_nearest),
      .prt_o   (prot_wr_en),
      .rpc_o   (ret_pc)
   );

   assign ovf_flag  = st_flag[BIT_OVF];
   assign unf_flag  = st_flag[BIT_UNF];
   assign ovf_irq   = st_irq[BIT_OVF];
   assign unf_irq   = st_irq[BIT_UNF];
   assign neg_flag  = cond_q.neg;
   assign zero_flag = cond_q.zero;
   assign test_flag = cond_q.test;

   always_comb begin
      stat_word                  = '0;
      stat_word[BIT_OVF]         = ovf_flag;
      stat_word[BIT_UNF]         = unf_flag;
      stat_word[BIT_NEG]         = neg_flag;
      stat_word[BIT_ZRO]         = zero_flag;
      stat_word[BIT_TST]         = test_flag;
      stat_word[BIT_RND]         = rnd_nearest;
      stat_word[BIT_PRT]         = prot_wr_en;
      stat_word[RPC_MSB:RPC_LSB] = ret_pc;
   end

   p_arith_keeps_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_arith && !upd_nz && !upd_test && !ld_en && !call_en) |=>
         ($stable(neg_flag) && $stable(zero_flag) && $stable(test_flag) && $stable(ret_pc)));
   p_load_restores_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !upd_arith && !upd_nz && !upd_test && !call_en) |=>
         (stat_word == ($past(ld_data) & ((({DATA_W{1'b0}} | {RPC_W{1'b1}}) << RPC_LSB)
                                          | {{(DATA_W-CTL_BITS){1'b0}}, {CTL_BITS{1'b1}}}))));
endmodule

// File: tb/fpu_status_reg_tb.sv
`timescale 1ns/1ps
module fpu_status_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_arith = 0, ovf_in = 0, unf_in = 0;
   logic        upd_nz = 0, neg_in = 0, zero_in = 0;
   logic        upd_test = 0, test_in = 0;
   logic        call_en = 0;
   logic [15:0] call_pc = '0;
   logic        ld_en = 0;
   logic [31:0] ld_data = '0;

   logic [31:0] a_word, b_word;
   logic        a_ovf, a_unf, a_neg, a_zero, a_test, a_rnd, a_prt, a_oirq, a_uirq;
   logic        b_ovf, b_unf, b_neg, b_zero, b_test, b_rnd, b_prt, b_oirq, b_uirq;
   logic [15:0] a_rpc;
   logic [7:0]  b_rpc;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   fpu_status_reg #(.DATA_W(32), .RPC_W(16), .RPC_LSB(16), .IRQ_PULSE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .upd_arith(upd_arith), .ovf_in(ovf_in), .unf_in(unf_in),
      .upd_nz(upd_nz), .neg_in(neg_in), .zero_in(zero_in), .upd_test(upd_test),
      .test_in(test_in), .call_en(call_en), .call_pc(call_pc), .ld_en(ld_en),
      .ld_data(ld_data), .stat_word(a_word), .ovf_flag(a_ovf), .unf_flag(a_unf),
      .neg_flag(a_neg), .zero_flag(a_zero), .test_flag(a_test), .rnd_nearest(a_rnd),
      .prot_wr_en(a_prt), .ret_pc(a_rpc), .ovf_irq(a_oirq), .unf_irq(a_uirq));

   fpu_status_reg #(.DATA_W(32), .RPC_W(8), .RPC_LSB(20), .IRQ_PULSE(1'b0)) u_lvl (
      .clk(clk), .rst_n(rst_n), .upd_arith(upd_arith), .ovf_in(ovf_in), .unf_in(unf_in),
      .upd_nz(upd_nz), .neg_in(neg_in), .zero_in(zero_in), .upd_test(upd_test),
      .test_in(test_in), .call_en(call_en), .call_pc(call_pc[7:0]), .ld_en(ld_en),
      .ld_data(ld_data), .stat_word(b_word), .ovf_flag(b_ovf), .unf_flag(b_unf),
      .neg_flag(b_neg), .zero_flag(b_zero), .test_flag(b_test), .rnd_nearest(b_rnd),
      .prot_wr_en(b_prt), .ret_pc(b_rpc), .ovf_irq(b_oirq), .unf_irq(b_uirq));

   function automatic logic [31:0] pk(input logic [6:0] ctl, input logic [31:0] rpc,
                                      input int lsb, input int w);
      logic [31:0] m;
      m = (32'h1 << w) - 32'h1;
      return {25'b0, ctl} | ((rpc & m) << lsb);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      upd_arith = 0; ovf_in = 0; unf_in = 0; upd_nz = 0; neg_in = 0; zero_in = 0;
      upd_test = 0; test_in = 0; call_en = 0; ld_en = 0; ld_data = '0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic t_reset();
      chk("R10", "word a", a_word, 32'h0);
      chk("R10", "word b", b_word, 32'h0);
      chk("R10", "irq a", {30'b0, a_oirq, a_uirq}, 32'h0);
      chk("R9", "rnd/prot after reset", {30'b0, a_rnd, a_prt}, 32'h0);
   endtask

   task automatic t_sticky();
      upd_arith = 1; ovf_in = 1; neg_in = 1; zero_in = 1;
      step();
      chk("R1", "ovf set", a_word, 32'h1);
      chk("R5", "arith leaves N/Z b", b_word, 32'h1);
      chk("R2", "pulse irq first cycle", {31'b0, a_oirq}, 32'h1);
      chk("R2", "level irq", {31'b0, b_oirq}, 32'h1);
      step();
      chk("R1", "ovf holds", a_word, 32'h1);
      chk("R2", "pulse irq drops", {31'b0, a_oirq}, 32'h0);
      chk("R2", "level irq stays", {31'b0, b_oirq}, 32'h1);
      upd_arith = 1; ovf_in = 0; unf_in = 1;
      step();
      chk("R1", "zero qualifier keeps ovf, sets unf", a_word, 32'h3);
      chk("R2", "unf pulse", {30'b0, a_oirq, a_uirq}, 32'h1);
   endtask

   task automatic t_clear();
      ld_en = 1; ld_data = 32'h0; upd_arith = 1; ovf_in = 1;
      step();
      chk("R8", "set beats clear", a_word, 32'h1);
      chk("R2", "no pulse when already set", {31'b0, a_oirq}, 32'h0);
      ld_en = 1; ld_data = 32'h0;
      step();
      chk("R1", "load clears", a_word, 32'h0);
      chk("R2", "level irq follows clear", {31'b0, b_oirq}, 32'h0);
      upd_arith = 1; ovf_in = 1;
      step();
      chk("R2", "pulse re-armed", {31'b0, a_oirq}, 32'h1);
      ld_en = 1; ld_data = 32'h0;
      step();
   endtask

   task automatic t_cond();
      upd_nz = 1; neg_in = 1; zero_in = 0;
      step();
      chk("R3", "neg from strobe", a_word, 32'h4);
      upd_arith = 1; neg_in = 0; zero_in = 1; test_in = 1;
      step();
      chk("R3", "N/Z ignore other strobes", a_word, 32'h4);
      chk("R4", "test ignores arith strobe", {31'b0, a_test}, 32'h0);
      upd_test = 1; test_in = 1; neg_in = 0; zero_in = 1;
      step();
      chk("R4", "test set, N/Z kept", a_word, 32'h14);
      chk("R5", "test strobe isolation b", b_word, 32'h14);
   endtask

   task automatic t_prio();
      ld_en = 1; ld_data = 32'h0000_0068; upd_nz = 1; neg_in = 1; zero_in = 0;
      step();
      chk("R11", "strobe beats load for N/Z", a_word, 32'h64);
      chk("R9", "round to nearest selected", {31'b0, a_rnd}, 32'h1);
      chk("R9", "protected write enabled", {31'b0, b_prt}, 32'h1);
   endtask

   task automatic t_call();
      call_en = 1; call_pc = 16'hABCD;
      step();
      chk("R6", "call a", {16'b0, a_rpc}, 32'hABCD);
      chk("R6", "call b truncated", {24'b0, b_rpc}, 32'hCD);
      chk("R7", "word a layout", a_word, pk(7'h64, 32'hABCD, 16, 16));
      chk("R7", "word b layout", b_word, pk(7'h64, 32'hCD, 20, 8));
      call_en = 1; call_pc = 16'h1234; ld_en = 1; ld_data = 32'hFFFF_FFFF;
      step();
      chk("R6", "call beats load a", a_word, pk(7'h7F, 32'h1234, 16, 16));
      chk("R7", "reserved zero b", b_word, pk(7'h7F, 32'h34, 20, 8));
   endtask

   task automatic t_save_restore();
      logic [31:0] saved;
      saved = a_word;
      ld_en = 1; ld_data = 32'h0;
      step();
      chk("R7", "cleared before restore", a_word, 32'h0);
      ld_en = 1; ld_data = saved;
      step();
      chk("R7", "restore exact a", a_word, saved);
      chk("R7", "restore b from other layout", b_word, pk(7'h7F, saved >> 20, 20, 8));
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_sticky();
      t_clear();
      t_cond();
      t_prio();
      t_call();
      t_save_restore();
      done = 1;
      summary();
   end
endmodule